// File: doc/BRIEF.md
# Ramp-Compare Sampler Controller

This controller turns an analog signal into 4-bit samples using nothing but digital pins. A small resistor ladder outside the chip converts the controller's level code into a voltage, and that voltage is added to the biased input signal. A single comparator bit goes high once the sum passes the logic threshold. At the start of every sample period the controller raises the code by one level per step slot, beginning at zero. At the first step boundary where the comparator reads high, it stops climbing, drops the code back to zero and reports the level it had reached as the new sample.

Each period has a fixed number of step slots, 32 by default, and the 16 levels fit in the first half of the period. Once the ramp is done, the code stays at zero until the next period begins. The step and period timing come from a clock-enable divider derived from the system clock frequency, the sample rate (13200 per second by default) and the slot count. Each finished sample comes with a one-cycle strobe, and a toggle output flips so the sample rate can be watched on a pin.

The result port has no ready input and cannot apply back-pressure. The conversion rate is fixed by the analog timing, so the consumer must take every strobe. The sample value and its flag stay valid until the next strobe.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: The 4-bit level code `dac_code` rises by exactly one at each step boundary during a ramp, and a step lasts CLK_HZ/(SAMPLE_HZ*STEPS_PER_SAMPLE) clock cycles. The only other change it can make is a return to 0.
- R2: The first step of every sample period, which lasts STEPS_PER_SAMPLE steps, starts at code 0. This includes the period that begins right after reset.
- R3: The comparator passes through a two-flop synchronizer and is examined only at step boundaries. The value present at `cmp_in` two clock cycles before a boundary edge decides that boundary. If it is high, the level that was held during the ending step becomes the sample.
- R4: On the edge where a sample is decided, `dac_code` goes to 0. It stays at 0 for the rest of the period, whatever `cmp_in` does.
- R5: If no trip has been seen by the boundary that ends level 15, the sample saturates at 15 with `sample_ovf` = 1. A trip at level 15 gives 15 with `sample_ovf` = 0.
- R6: `sample_valid` is high for exactly one cycle per sample period, on the decision edge. `sample` and `sample_ovf` change only with that strobe and are held otherwise.
- R7: `sample_toggle` inverts each time a sample is delivered.
- R8: A synchronous reset sets `dac_code`, `sample`, `sample_ovf`, `sample_valid` and `sample_toggle` to 0 and restarts the period timing.
- R9: A comparator pulse that lies outside the decision window of R3 has no effect. The ramp continues and the sample saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator bit, high when the summed voltage is above threshold |
| dac_code | output | 4 | Level code driving the external ladder |
| sample | output | 4 | Last converted sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_ovf | output | 1 | Sample saturated without a trip |
| sample_toggle | output | 1 | Inverts on every delivered sample |

## Verification
Two events can land on the same step boundary: a comparator trip and saturation at level 15. The bench provokes this with a threshold of exactly 15 and with a comparator pulse placed in the decision window of the final boundary. It expects 15 with no overflow in both cases, and a threshold of 16 must give 15 with overflow set. A further coincidence is a comparator already high when the ramp has finished, or high during reset. The bench judges this by the zero code and by the absence of a second strobe in that period.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RAMP = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/radc_tick_gen.sv
module radc_tick_gen #(
  parameter int CYC_PER_STEP     = 4,
  parameter int STEPS_PER_SAMPLE = 32
) (
  input  logic clk,
  input  logic rst,
  output logic step_tick,
  output logic period_end
);
  localparam int SW = (STEPS_PER_SAMPLE > 1) ? $clog2(STEPS_PER_SAMPLE) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(STEPS_PER_SAMPLE - 1);

  logic [SW-1:0] slot;

  generate
    if (CYC_PER_STEP <= 1) begin : g_every_cycle
      assign step_tick = 1'b1;
    end else begin : g_divider
      localparam int CW = $clog2(CYC_PER_STEP);
      localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_STEP - 1);
      logic [CW-1:0] cyc;
      always_ff @(posedge clk) begin
        if (rst || cyc == CYC_LAST) cyc <= '0;
        else                        cyc <= cyc + 1'b1;
      end
      assign step_tick = (cyc == CYC_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            slot <= '0;
    else if (step_tick) slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
  end

  assign period_end = step_tick && (slot == SLOT_LAST);
endmodule

// File: rtl/radc_sync.sv
module radc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/radc_ramp_core.sv
module radc_ramp_core
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_tick,
  input  logic              period_end,
  input  logic              trip,
  output logic [CODE_W-1:0] level,
  output logic [CODE_W-1:0] result,
  output logic              result_ovf,
  output logic              result_stb,
  output logic              result_tgl
);
  localparam logic [CODE_W-1:0] LVL_TOP = '1;

  ramp_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RAMP;
      level      <= '0;
      result     <= '0;
      result_ovf <= 1'b0;
      result_stb <= 1'b0;
      result_tgl <= 1'b0;
    end else begin
      result_stb <= 1'b0;
      if (step_tick) begin
        if (period_end) begin
          state <= ST_RAMP;
          level <= '0;
        end else if (state == ST_RAMP) begin
          if (trip || level == LVL_TOP) begin
            result     <= level;
            result_ovf <= !trip;
            result_stb <= 1'b1;
            result_tgl <= ~result_tgl;
            state      <= ST_HOLD;
            level      <= '0;
          end else begin
            level <= level + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CLK_HZ           = 125_000_000,
  parameter int SAMPLE_HZ        = 13_200,
  parameter int STEPS_PER_SAMPLE = 32,
  parameter int CODE_W           = 4,
  parameter int SYNC_STAGES      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] sample,
  output logic              sample_valid,
  output logic              sample_ovf,
  output logic              sample_toggle
);
  localparam int CYC_PER_STEP = CLK_HZ / (SAMPLE_HZ * STEPS_PER_SAMPLE);

  logic step_tick, period_end, cmp_sync;

  radc_tick_gen #(
    .CYC_PER_STEP    (CYC_PER_STEP),
    .STEPS_PER_SAMPLE(STEPS_PER_SAMPLE)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .step_tick (step_tick),
    .period_end(period_end)
  );

  radc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (cmp_in),
    .q  (cmp_sync)
  );

  radc_ramp_core #(.CODE_W(CODE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .step_tick (step_tick),
    .period_end(period_end),
    .trip      (cmp_sync),
    .level     (dac_code),
    .result    (sample),
    .result_ovf(sample_ovf),
    .result_stb(sample_valid),
    .result_tgl(sample_toggle)
  );
endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] sample,
  input logic              sample_valid,
  input logic              sample_ovf,
  input logic              sample_toggle
);
  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R4
  code_zero_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (dac_code == '0));

  // R1
  code_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code)) |->
      (dac_code == CODE_W'($past(dac_code) + 1'b1) || dac_code == '0));

  // R5
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && sample_ovf) |-> (sample == '1));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> ($stable(sample) && $stable(sample_ovf)));

  // R7
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (sample_toggle != $past(sample_toggle)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !sample_valid && sample == '0 && !sample_ovf));
endmodule

bind ramp_adc_ctrl ramp_adc_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dac_code     (dac_code),
  .sample       (sample),
  .sample_valid (sample_valid),
  .sample_ovf   (sample_ovf),
  .sample_toggle(sample_toggle)
);

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
  localparam int STEP_CYC = 4;
  localparam int SLOTS    = 32;
  localparam int PER_CYC  = STEP_CYC * SLOTS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in = 1'b0;
  logic [3:0] dac_code, sample;
  logic sample_valid, sample_ovf, sample_toggle;

  int tests = 0;
  int fails = 0;
  bit tog_exp = 1'b0;

  always #4 clk = ~clk;

  ramp_adc_ctrl #(
    .CLK_HZ          (STEP_CYC * SLOTS * 13_200),
    .SAMPLE_HZ       (13_200),
    .STEPS_PER_SAMPLE(SLOTS),
    .CODE_W          (4)
  ) u_ramp_adc_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmp_in       (cmp_in),
    .dac_code     (dac_code),
    .sample       (sample),
    .sample_valid (sample_valid),
    .sample_ovf   (sample_ovf),
    .sample_toggle(sample_toggle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_reset_state();
    check(dac_code == 4'd0, "R8 code", int'(dac_code), 0);
    check(sample_valid == 1'b0, "R8 valid", int'(sample_valid), 0);
    check(sample == 4'd0, "R8 sample", int'(sample), 0);
    check(sample_ovf == 1'b0, "R8 ovf", int'(sample_ovf), 0);
    check(sample_toggle == 1'b0, "R8 toggle", int'(sample_toggle), 0);
  endtask

  // thr: level at which the comparator goes high (16 = never)
  // pulse_at: >0 gives a one-cycle comparator pulse before that local edge
  // stop_at: >0 ends the period early after that many edges
  task automatic run_period(input int thr, input int pulse_at, input int stop_at);
    int teff, lvl, dec;
    if (pulse_at > 0) teff = (pulse_at % STEP_CYC == 2) ? (pulse_at - 2) / STEP_CYC : 16;
    else              teff = thr;
    lvl = (teff > 15) ? 15 : teff;
    dec = lvl + 1;
    for (int i = 1; i <= PER_CYC; i++) begin
      int j, exp_code;
      bit exp_v;
      if (pulse_at > 0) cmp_in = (i == pulse_at);
      else              cmp_in = (int'(dac_code) >= thr);
      @(posedge clk);
      @(negedge clk);
      j = i / STEP_CYC;
      exp_code = (j < dec) ? j : 0;
      // R1 R2 R4: ramp shape within the period
      check(int'(dac_code) == exp_code, "R1/R2/R4 code", int'(dac_code), exp_code);
      exp_v = (i == STEP_CYC * dec);
      // R6: strobe timing
      check(sample_valid == exp_v, "R6 valid", int'(sample_valid), int'(exp_v));
      if (exp_v) begin
        tog_exp = ~tog_exp;
        // R3 R5 R9: captured value and overflow flag
        check(int'(sample) == lvl, "R3/R5/R9 sample", int'(sample), lvl);
        check(sample_ovf == (teff > 15), "R5 ovf", int'(sample_ovf), int'(teff > 15));
      end
      // R7
      check(sample_toggle == tog_exp, "R7 toggle", int'(sample_toggle), int'(tog_exp));
      if (stop_at > 0 && i >= stop_at) return;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    tog_exp = 1'b0;
    // R3 R5: every comparator threshold, including coincident trip and saturation
    for (int t = 0; t <= 16; t++) run_period(t, 0, 0);
    // R9: pulses outside the decision window are ignored
    run_period(0, 1, 0);
    run_period(0, 4, 0);
    run_period(0, 13, 0);
    run_period(0, 3, 0);
    // R3: pulses inside the decision window trip at a known level
    run_period(0, 30, 0);
    run_period(0, 2, 0);
    run_period(0, 62, 0);
    // R8: reset in the middle of a ramp with the comparator held high
    run_period(9, 0, 22);
    rst = 1'b1;
    cmp_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    cmp_in = 1'b0;
    tog_exp = 1'b0;
    run_period(5, 0, 0);
    run_period(16, 0, 0);
    run_period(15, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule